// File: doc/BRIEF.md
# Eight-Lane Bit-Sliced Frame Transmitter

This block feeds eight identical receive-only serial devices at the same time. The devices share one bit clock and each has its own data line. The host presents eight frames of equal length on a wide input bus, one frame per device, and pulses a start strobe. The block latches all eight frames in that cycle. It then shifts them out in lockstep, so that in every bit period the eight-bit output word holds one bit from each frame.

The devices have no select input. Their common clock therefore toggles only while a transfer is in progress, and it rests low otherwise. The system clock runs at four times the bit rate: 100 MHz in, 25 MHz out. Data lanes change together with the falling edge of the bit clock. They hold steady for two system cycles on each side of the rising edge, and that rising edge is where the devices sample.

A busy flag covers the transfer. A one-cycle done strobe marks its end. Any start strobe that arrives while busy is high is dropped.

Top module: `parallelLaneTx`

## Requirements
- R1: After reset and whenever no transfer is running, bitClk, every bit of laneData, busy and done are all low.
- R2: A start pulse sampled while busy is low latches all eight frames from frameIn, and busy is high in the very next cycle. Frame l occupies frameIn[l*366 +: 366].
- R3: During a transfer, each bit period lasts four system cycles. bitClk is low for the first two cycles and high for the last two, and it has exactly 366 rising edges per transfer.
- R4: Output bit laneData[l] carries the current bit of frame l, for l = 0 to 7.
- R5: Frames leave most significant bit first. Bit 365 of each frame is presented in the first bit period, and bit 0 in the last.
- R6: laneData changes only in a cycle where bitClk is low, and it never changes while bitClk is high.
- R7: busy stays high for exactly 366 × 4 = 1464 system cycles. In the cycle after that it is low and done is high, and done is high for one cycle only.
- R8: A start pulse while busy is high has no effect. The running transfer keeps its original data and its length, even if frameIn changes.
- R9: A start pulse in the cycle where done is high is accepted, and the next transfer begins in the following cycle with that frame's bit 365 on the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transfer request strobe |
| frameIn | input | 2928 | Eight concatenated 366-bit frames; frame l at bits l*366 and up |
| bitClk | output | 1 | Shared bit clock for all devices |
| laneData | output | 8 | One data line per device, bit l for device l |
| busy | output | 1 | High while a transfer is being shifted out |
| done | output | 1 | One-cycle strobe after the last bit period |

## Verification
Random frames from a fixed seed check that every lane follows only its own frame, so a lane swap or a wrong frame slice shows up. Frames of all zeros and all ones expose stuck lanes and clock gating faults. A frame with a single set bit at a different position in each lane pins down MSB-first order and per-lane indexing together. A start pulse during a transfer, with frameIn inverted, tells apart a design that re-latches or restarts. A restart strobe in the done cycle checks the hand-over from one transfer to the next.

// File: rtl/laneTxPkg.sv
package laneTxPkg;

  // Strobes from the sequencer to the frame datapath
  typedef struct packed {
    logic load;   // latch all frames, start of a transfer
    logic shift;  // advance every lane to its next bit
    logic clear;  // end of transfer, drop lanes to zero
  } ctrlStrobes_t;

endpackage

// File: rtl/laneTxCtrl.sv
module laneTxCtrl
  import laneTxPkg::*;
#(
  parameter int FRAME_BITS = 366,
  parameter int CLK_DIV    = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         bitClk,
  output logic         done
);

  localparam int PW         = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BW         = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam int HALF       = CLK_DIV / 2;
  localparam int LAST_PHASE = CLK_DIV - 1;

  logic [PW-1:0] phase;
  logic [PW-1:0] phaseNext;
  logic [BW-1:0] bitCnt;
  logic          busyQ;
  logic          bitClkQ;
  logic          doneQ;
  logic          phaseLast;
  logic          bitLast;

  assign phaseLast = (phase == PW'(LAST_PHASE));
  assign bitLast   = (bitCnt == BW'(FRAME_BITS - 1));

  always_comb begin
    strobes       = '0;
    strobes.load  = !busyQ && start;
    strobes.shift = busyQ && phaseLast && !bitLast;
    strobes.clear = busyQ && phaseLast && bitLast;
  end

  always_comb begin
    if (strobes.load || phaseLast) begin
      phaseNext = '0;
    end else begin
      phaseNext = phase + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      phase   <= '0;
      bitCnt  <= '0;
      bitClkQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobes.clear;
      if (strobes.load) begin
        busyQ   <= 1'b1;
        phase   <= '0;
        bitCnt  <= '0;
        bitClkQ <= 1'b0;
      end else if (busyQ) begin
        phase <= phaseNext;
        if (strobes.clear) begin
          busyQ   <= 1'b0;
          bitCnt  <= '0;
          bitClkQ <= 1'b0;
        end else begin
          if (strobes.shift) begin
            bitCnt <= bitCnt + BW'(1);
          end
          bitClkQ <= (phaseNext >= PW'(HALF));
        end
      end else begin
        phase   <= '0;
        bitClkQ <= 1'b0;
      end
    end
  end

  assign busy   = busyQ;
  assign bitClk = bitClkQ;
  assign done   = doneQ;

endmodule

// File: rtl/laneTxData.sv
module laneTxData
  import laneTxPkg::*;
#(
  parameter int LANES      = 8,
  parameter int FRAME_BITS = 366
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [LANES*FRAME_BITS-1:0] frameIn,
  output logic [LANES-1:0]            laneData
);

  localparam int MSB = FRAME_BITS - 1;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [FRAME_BITS-1:0] shiftReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftReg <= '0;
      end else if (strobes.load) begin
        shiftReg <= frameIn[lane*FRAME_BITS +: FRAME_BITS];
      end else if (strobes.shift) begin
        shiftReg <= {shiftReg[MSB-1:0], 1'b0};
      end else if (strobes.clear) begin
        shiftReg <= '0;
      end
    end

    // bit-slice: lane position in the output word equals device index
    assign laneData[lane] = shiftReg[MSB];
  end

endmodule

// File: rtl/parallelLaneTx.sv
module parallelLaneTx #(
  parameter int LANES      = 8,
  parameter int FRAME_BITS = 366,
  parameter int CLK_DIV    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [LANES*FRAME_BITS-1:0] frameIn,
  output logic                        bitClk,
  output logic [LANES-1:0]            laneData,
  output logic                        busy,
  output logic                        done
);

  laneTxPkg::ctrlStrobes_t strobes;

  laneTxCtrl #(
    .FRAME_BITS(FRAME_BITS),
    .CLK_DIV   (CLK_DIV)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .busy   (busy),
    .bitClk (bitClk),
    .done   (done)
  );

  laneTxData #(
    .LANES     (LANES),
    .FRAME_BITS(FRAME_BITS)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .frameIn (frameIn),
    .laneData(laneData)
  );

endmodule

// File: rtl/laneTxChk.sv
module laneTxChk #(
  parameter int LANES      = 8,
  parameter int FRAME_BITS = 366,
  parameter int CLK_DIV    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             bitClk,
  input logic [LANES-1:0] laneData,
  input logic             busy,
  input logic             done
);

  localparam int HALF  = CLK_DIV / 2;
  localparam int TOTAL = FRAME_BITS * CLK_DIV;
  localparam int CW    = $clog2(TOTAL + 1) + 1;
  localparam int RW    = $clog2(CLK_DIV + 1) + 1;

  logic [CW-1:0] busyCnt;
  logic [RW-1:0] runLen;
  logic          prevClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      runLen  <= '0;
      prevClk <= 1'b0;
    end else begin
      prevClk <= bitClk;
      busyCnt <= busy ? busyCnt + CW'(1) : '0;
      if (!busy) begin
        runLen <= '0;
      end else if (bitClk != prevClk) begin
        runLen <= RW'(1);
      end else begin
        runLen <= runLen + RW'(1);
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!bitClk && laneData == '0));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  clk_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitClk != prevClk) |-> runLen == RW'(HALF));

  // R3
  clk_run_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen <= RW'(HALF));

  // R6
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitClk |-> $stable(laneData));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && busyCnt == CW'(TOTAL)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind parallelLaneTx laneTxChk #(
  .LANES     (LANES),
  .FRAME_BITS(FRAME_BITS),
  .CLK_DIV   (CLK_DIV)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .bitClk  (bitClk),
  .laneData(laneData),
  .busy    (busy),
  .done    (done)
);

// File: tb/test_parallelLaneTx.sv
module test_parallelLaneTx;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 8;
  localparam int FB         = 366;
  localparam int DIV        = 4;
  localparam int TOTAL      = LANES * FB;
  localparam int XFER       = FB * DIV;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [TOTAL-1:0] frameIn = '0;
  logic             bitClk;
  logic [LANES-1:0] laneData;
  logic             busy;
  logic             done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parallelLaneTx i_parallelLaneTx (
    .clk(clk), .rstN(rstN), .start(start), .frameIn(frameIn),
    .bitClk(bitClk), .laneData(laneData), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at time %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LANES-1:0] expLanes(input logic [TOTAL-1:0] f, input int k);
    logic [LANES-1:0] w;
    for (int l = 0; l < LANES; l++) w[l] = f[l*FB + (FB-1-k)];
    return w;
  endfunction

  function automatic logic [TOTAL-1:0] randFrames();
    logic [TOTAL-1:0] f;
    for (int i = 0; i < TOTAL; i++) f[i] = 1'($urandom_range(0, 1));
    return f;
  endfunction

  // Starts a transfer and follows it cycle by cycle; optional mid-run start with inverted data
  task automatic runXfer(input logic [TOTAL-1:0] f, input bit disturb);
    int rises = 0;
    logic prev = 1'b0;
    @(negedge clk);
    frameIn = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < XFER; c++) begin
      check(busy === 1'b1, "R7 busy high", int'(busy), 1);
      check(bitClk === ((c % DIV) >= DIV/2), "R3 bitClk phase", int'(bitClk), int'((c % DIV) >= DIV/2));
      check(laneData === expLanes(f, c / DIV), disturb ? "R8 lanes keep latched data" : "R4 R5 lane bit",
            int'(laneData), int'(expLanes(f, c / DIV)));
      if (bitClk && !prev) rises++;
      prev = bitClk;
      if (disturb && c == 37) begin
        start = 1'b1;
        frameIn = ~f;
      end
      if (disturb && c == 38) start = 1'b0;
      @(negedge clk);
    end
    check(rises == FB, "R3 rising edge count", rises, FB);
    check(done === 1'b1 && busy === 1'b0, "R7 done after last bit", {30'd0, done, busy}, 2);
    check(bitClk === 1'b0 && laneData === '0, "R1 quiet after transfer", int'({bitClk, laneData}), 0);
    @(negedge clk);
    check(done === 1'b0, "R7 done single cycle", int'(done), 0);
    check(busy === 1'b0, "R8 no restart from ignored start", int'(busy), 0);
  endtask

  initial begin : watchdog
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    logic [TOTAL-1:0] f;
    logic [TOTAL-1:0] g;
    void'($urandom(32'd20141006));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(bitClk === 1'b0 && laneData === '0 && busy === 1'b0 && done === 1'b0,
          "R1 reset state", int'({bitClk, busy, done, laneData}), 0);

    // R2: accepted start raises busy next cycle
    f = randFrames();
    runXfer(f, 1'b0);

    // all zeros and all ones
    runXfer('0, 1'b0);
    runXfer('1, 1'b0);

    // R5 R4: one set bit, at a different position per lane
    f = '0;
    for (int l = 0; l < LANES; l++) f[l*FB + (FB-1 - l*45)] = 1'b1;
    runXfer(f, 1'b0);

    // random frames
    for (int n = 0; n < 3; n++) begin
      f = randFrames();
      runXfer(f, 1'b0);
    end

    // R8: start while busy, with inverted frameIn
    f = randFrames();
    runXfer(f, 1'b1);

    // R9: restart in the done cycle
    f = randFrames();
    g = randFrames();
    @(negedge clk);
    frameIn = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (XFER) @(negedge clk);
    check(done === 1'b1, "R9 done before restart", int'(done), 1);
    frameIn = g;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9 restart accepted", int'(busy), 1);
    check(laneData === expLanes(g, 0), "R9 new frame MSB", int'(laneData), int'(expLanes(g, 0)));
    repeat (XFER) @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R9 second transfer ends", {30'd0, done, busy}, 2);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule